// File: doc/BRIEF.md
# Dual-Bank Level Interrupt Controller

This block collects 64 level-type interrupt inputs and presents them to a processor as a single request line. Each input has a pending flag, set when the input is sampled high, and an enable bit that decides whether the flag reaches the output. The sources are split into a low bank (0 to 31) and an extended bank (32 to 63). Each bank has its own clear, enable and masked-status word in a small register space.

Software services an interrupt by reading a vector word. That word names the winning source: the lowest-numbered active source in the low bank, and otherwise the lowest-numbered active source in the extended bank. Software then writes a one to that source's clear bit. An input that is still asserted sets its flag again, so a level source keeps requesting until its device drops it.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: After reset, all enable bits and pending flags are 0, `irq_out` is 0 and `bus_rdata` is 0.
- R2: A source input sampled high on a clock edge sets its pending flag at that edge. The flag stays set after the input drops until software clears it.
- R3: A write to offset 0x00 clears the pending flag of source i (bits 31:0 map to sources 0 to 31) for each one bit i in the write data. A write to offset 0x04 does the same for sources 32+i. Zero bits leave their flags unchanged.
- R4: When a clear and a high source sample fall on the same edge for one flag, the flag ends up set.
- R5: Offset 0x10 holds the enable bits of sources 0 to 31 and offset 0x14 those of sources 32 to 63, bit i for source i or 32+i. Both are writable and read back as written.
- R6: A read of offset 0x18 returns the low-bank pending flags ANDed with the low-bank enables. Offset 0x1C returns the same for the extended bank.
- R7: `irq_out` is high exactly when some source is both pending and enabled.
- R8: A read of offset 0x20 returns the winning source index in bits 5:0 and a valid flag in bit 31, with all other bits 0. The winner is the lowest set bit of the low masked status if that status is nonzero, and otherwise 32 plus the lowest set bit of the extended masked status. With no enabled pending source the word is 0.
- R9: Read data appears on `bus_rdata` in the cycle after the read strobe and shows the state before that strobe's edge. In a cycle after a cycle without a read strobe, `bus_rdata` is 0.
- R10: Reads of undefined offsets and of offset 0x08 return 0. Writes to undefined offsets, to the status words and to the vector word change no state.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_src | input | 64 | Level interrupt inputs, bit i is source i |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read, qualified by bus_sel |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Two functions can act on the same pending flag in one cycle: a raw source setting the flag and a software clear acknowledging it. The bench holds a source high across the edge that carries the clear write. It then drops the source and reads the masked status, which must still show the flag; a second clear with the source low must remove it. A read strobe that coincides with a source pulse is also checked: it must return the status from before that edge.

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       irq_src,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] OFS_CLR_LO  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_CLR_HI  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_EN_LO   = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_EN_HI   = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFS_STAT_LO = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFS_STAT_HI = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] OFS_VEC     = ADDR_W'('h20);

  logic [63:0] pend_q, en_q, mstat, clr_mask;
  logic [31:0] rd_val;
  logic [5:0]  win_idx;
  logic        win_vld, wr_en, rd_en;

  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign clr_mask = {(wr_en && bus_addr == OFS_CLR_HI) ? bus_wdata : 32'h0,
                     (wr_en && bus_addr == OFS_CLR_LO) ? bus_wdata : 32'h0};
  assign mstat    = pend_q & en_q;
  assign irq_out  = |mstat;

  always_comb begin
    win_idx = '0;
    win_vld = 1'b0;
    for (int i = 63; i >= 0; i--) begin
      if (mstat[i]) begin
        win_idx = 6'(i);
        win_vld = 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_EN_LO:   rd_val = en_q[31:0];
      OFS_EN_HI:   rd_val = en_q[63:32];
      OFS_STAT_LO: rd_val = mstat[31:0];
      OFS_STAT_HI: rd_val = mstat[63:32];
      OFS_VEC:     rd_val = {win_vld, 25'h0, win_idx};
      default:     rd_val = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      en_q      <= '0;
      bus_rdata <= '0;
    end else begin
      pend_q    <= irq_src | (pend_q & ~clr_mask);
      if (wr_en && bus_addr == OFS_EN_LO) en_q[31:0]  <= bus_wdata;
      if (wr_en && bus_addr == OFS_EN_HI) en_q[63:32] <= bus_wdata;
      bus_rdata <= rd_en ? rd_val : 32'h0;
    end
  end

  p_src_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(irq_src)) == $past(irq_src)));

  p_flag_drop_needs_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_mask)) == 64'h0));

  p_irq_matches_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == win_vld);

  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (bus_rdata == 32'h0));

  // R10 as well: only enable-word writes may move the enables
  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (bus_addr == OFS_EN_LO || bus_addr == OFS_EN_HI)) |=> $stable(en_q));
endmodule

// File: tb/dual_bank_irq_ctrl_test.sv
module dual_bank_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_src = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  dual_bank_irq_ctrl #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  // {source pulse, enables, expected vector word}
  localparam logic [159:0] TBL [7] = '{
    {64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0000},
    {64'h8000_0000_0000_0010, 64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_0004},
    {64'h0000_0100_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_0028},
    {64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 32'h8000_001F},
    {64'h0000_0001_0000_0006, 64'h0000_0001_FFFF_FFF9, 32'h8000_0020},
    {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 32'h8000_003F},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk); bus_sel = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [63:0] v);
    @(negedge clk); irq_src = v;
    @(negedge clk); irq_src = '0;
  endtask

  task automatic clear_all();
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] src, en, m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq_out", {63'h0, irq_out}, 64'h0);
    chk("R1 rdata", {32'h0, bus_rdata}, 64'h0);
    rd(8'h10, d); chk("R1 en lo", {32'h0, d}, 64'h0);
    rd(8'h14, d); chk("R1 en hi", {32'h0, d}, 64'h0);
    rd(8'h20, d); chk("R1 vector", {32'h0, d}, 64'h0);

    for (int k = 0; k < 7; k++) begin
      src = TBL[k][159:96]; en = TBL[k][95:32];
      m = src & en;
      clear_all();
      wr(8'h10, en[31:0]); wr(8'h14, en[63:32]);
      pulse(src);
      chk("R7 irq_out table", {63'h0, irq_out}, {63'h0, |m});
      rd(8'h18, d); chk("R6 status lo table", {32'h0, d}, {32'h0, m[31:0]});
      rd(8'h1C, d); chk("R6 status hi table", {32'h0, d}, {32'h0, m[63:32]});
      rd(8'h20, d); chk("R8 vector table", {32'h0, d}, {32'h0, TBL[k][31:0]});
    end

    // R5 enable readback
    wr(8'h10, 32'hA5A5_0F0F); wr(8'h14, 32'h1234_5678);
    rd(8'h10, d); chk("R5 en lo", {32'h0, d}, 64'hA5A5_0F0F);
    rd(8'h14, d); chk("R5 en hi", {32'h0, d}, 64'h1234_5678);

    // R2 flag held while masked, then visible once enabled
    clear_all(); wr(8'h10, 32'h0); wr(8'h14, 32'h0);
    pulse(64'h0000_0004_0000_0028);
    chk("R2 masked irq_out", {63'h0, irq_out}, 64'h0);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h18, d); chk("R2 held lo", {32'h0, d}, 64'h28);
    rd(8'h1C, d); chk("R2 held hi", {32'h0, d}, 64'h4);

    // R3 selective clear; zero bits keep flags
    wr(8'h00, 32'h0000_0008);
    rd(8'h18, d); chk("R3 clear one bit", {32'h0, d}, 64'h20);
    wr(8'h04, 32'h0);
    rd(8'h1C, d); chk("R3 zero write keeps", {32'h0, d}, 64'h4);
    wr(8'h04, 32'h4);
    rd(8'h1C, d); chk("R3 clear hi", {32'h0, d}, 64'h0);
    rd(8'h20, d); chk("R8 vector after clear", {32'h0, d}, 64'h8000_0005);

    // R4 set wins over clear on same edge
    clear_all();
    @(negedge clk); irq_src = 64'h80;
    wr(8'h00, 32'h80);
    irq_src = '0;
    rd(8'h18, d); chk("R4 set wins", {32'h0, d}, 64'h80);
    wr(8'h00, 32'h80);
    rd(8'h18, d); chk("R4 clear after drop", {32'h0, d}, 64'h0);

    // R9 read shows state before its edge; idle rdata is zero
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h18; irq_src = 64'h1;
    @(negedge clk); bus_sel = 1'b0; irq_src = '0;
    chk("R9 pre-edge state", {32'h0, bus_rdata}, 64'h0);
    rd(8'h18, d); chk("R9 later read", {32'h0, d}, 64'h1);
    @(negedge clk);
    chk("R9 idle rdata", {32'h0, bus_rdata}, 64'h0);

    // R10 undefined offsets and read-only words
    wr(8'h08, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h18, 32'h0); wr(8'h20, 32'h0);
    rd(8'h08, d); chk("R10 offset 08", {32'h0, d}, 64'h0);
    rd(8'h24, d); chk("R10 offset 24", {32'h0, d}, 64'h0);
    rd(8'h10, d); chk("R10 en lo kept", {32'h0, d}, 64'hFFFF_FFFF);
    rd(8'h18, d); chk("R10 status kept", {32'h0, d}, 64'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule